// File: doc/BRIEF.md
# Multiplexed-Bus Parallel ROM Byte Reader

This block fetches a single byte from an external parallel ROM whose address and data share one 8-bit bus. A read request carries a byte address (24 bits by default). The block sends it out as a series of bytes, most significant byte first. For each byte it generates one pulse on a ROM clock of its own. Each rising edge of that clock shifts the bus value into a chain of external cascaded registers, so the full address ends up on the ROM's address pins.

Once the address is in place, the block stops driving the bus. It lowers chip select for a programmable access window, and the read strobe follows a per-cycle mask within that window. The block captures the returned byte in the last strobed cycle and keeps it in a data register. It then drops its busy flag and marks the data valid.

The strobe mask and the window length are taken from the host when the request is accepted. A request that arrives while a read is running has no effect.

Top module: `prom_byte_reader`

## Requirements
- R1: After reset the address-latch enable, chip select and read strobe are high (inactive), the bus driver is disabled, the ROM clock is low, busy is low and the data-valid flag is low.
- R2: An accepted request sends the address as ADDR_BYTES beats on the bus, bits [23:16] first, then [15:8], then [7:0]. The bus driver is enabled for the whole address phase. After the last beat, the external chain holds bits [23:16], [15:8] and [7:0] in its third, second and first register.
- R3: The address-latch enable goes low in the first cycle after the request is accepted. It stays low through every beat and returns high only in the cycle after the high phase of the last beat's ROM clock.
- R4: Each beat takes two system cycles: one with the ROM clock low while the byte is presented, then one with the ROM clock high. A read produces exactly ADDR_BYTES rising ROM-clock edges, and the byte on the bus is unchanged at each rising edge.
- R5: Chip select goes low in the cycle right after the address phase. It stays low for exactly access_cnt_i+1 consecutive cycles, and the bus driver is disabled whenever chip select is low.
- R6: In window cycle k (k = 0 for the first chip-select cycle), the read strobe is low exactly when bit k of strobe_mask_i is 1 and k <= access_cnt_i. The read strobe is never low outside chip select.
- R7: The bus is captured in the last window cycle that has its strobe bit set. When no strobe bit falls inside the window, the bus is captured in the last window cycle.
- R8: Busy is high from the cycle after acceptance to the last window cycle inclusive. In the cycle after the window it is low, data-valid is high and data_o holds the captured byte.
- R9: A start pulse while busy is high is ignored. The address, mask, window length and timing of the running read are unchanged.
- R10: data_o and data_valid_o keep their values while idle. data_valid_o clears in the first cycle of an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request pulse, accepted only when idle |
| addr_i | input | 8*ADDR_BYTES | Byte address to read |
| strobe_mask_i | input | MASK_W | Read-strobe mask, one bit per window cycle |
| access_cnt_i | input | $clog2(MASK_W) | Window length minus one, in cycles |
| busy_o | output | 1 | Read in progress |
| data_o | output | 8 | Captured ROM byte |
| data_valid_o | output | 1 | data_o holds the result of the last read |
| bus_out_o | output | 8 | Value driven onto the shared bus |
| bus_oe_o | output | 1 | Bus driver enable |
| bus_in_i | input | 8 | Value seen on the shared bus |
| rom_clk_o | output | 1 | Clock for the external address registers |
| ale_n_o | output | 1 | Address-latch enable, active low |
| cs_n_o | output | 1 | ROM chip select, active low |
| rd_n_o | output | 1 | ROM read strobe, active low |

## Verification
Some properties are checked in every cycle: the read strobe only inside chip select, a released bus during chip select, the latch enable rising only after a ROM-clock high phase, the beat byte held steady at each rising edge, one-cycle clock phases, settings frozen while busy, and data held while idle. Other behaviour only shows up in the bench's scenarios, where a model of the three external registers and a ROM array runs against the block. These scenarios cover the reconstructed address, the per-cycle strobe pattern, the window length, the capture point when the mask is empty or lies outside the window, and the returned byte.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ADDR   = 2'd1,
      ST_ACCESS = 2'd2
   } rd_state_e;

   // Index of the highest set bit; 0 when the vector is empty.
   function automatic int unsigned top_set_bit(input logic [63:0] vec);
      int unsigned idx;
      idx = 0;
      for (int i = 0; i < 64; i++) begin
         if (vec[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/prom_addr_serializer.sv
module prom_addr_serializer #(
   parameter int BYTES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [8*BYTES-1:0]   addr_i,
   output logic [7:0]           byte_o,
   output logic                 rom_clk_o,
   output logic                 last_rise_o
);
   localparam int AW = 8 * BYTES;
   localparam int BW = $clog2(BYTES);

   initial begin : param_chk
      assert (BYTES >= 2 && BYTES <= 8) else $fatal(1, "BYTES out of range");
   end

   logic [AW-1:0] shreg_q;
   logic [BW-1:0] beat_q;
   logic          hi_q;
   logic          act_q;
   logic          at_last;

   assign at_last = (beat_q == BW'(BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         beat_q  <= '0;
         hi_q    <= 1'b0;
         act_q   <= 1'b0;
      end else if (load_i) begin
         shreg_q <= addr_i;
         beat_q  <= '0;
         hi_q    <= 1'b0;
         act_q   <= 1'b1;
      end else if (act_q) begin
         if (!hi_q) begin
            hi_q <= 1'b1;
         end else begin
            hi_q <= 1'b0;
            if (at_last) begin
               act_q <= 1'b0;
            end else begin
               beat_q  <= beat_q + 1'b1;
               shreg_q <= shreg_q << 8;
            end
         end
      end
   end

   assign byte_o      = shreg_q[AW-1 -: 8];
   assign rom_clk_o   = hi_q;
   assign last_rise_o = act_q & hi_q & at_last;

   // R4: byte already settled when the ROM clock rises
   assert_byte_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_clk_o) |-> $stable(byte_o));

   // R4: high phase lasts a single system cycle
   assert_clk_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rom_clk_o |=> !rom_clk_o);

endmodule

// File: rtl/prom_strobe_timer.sv
module prom_strobe_timer
   import prom_rd_pkg::*;
#(
   parameter int MASK_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       go_i,
   input  logic [MASK_W-1:0]          mask_i,
   input  logic [$clog2(MASK_W)-1:0]  cnt_i,
   output logic                       active_o,
   output logic                       rd_act_o,
   output logic                       sample_o,
   output logic                       last_o
);
   localparam int CW = $clog2(MASK_W);

   initial begin : param_chk
      assert (MASK_W >= 2 && MASK_W <= 64) else $fatal(1, "MASK_W out of range");
   end

   logic [MASK_W-1:0] win;
   logic [MASK_W-1:0] eff_d;
   logic [CW-1:0]     sidx_d;

   // One window bit per cycle allowed by the access count.
   for (genvar g = 0; g < MASK_W; g++) begin : g_win
      assign win[g] = (CW'(g) <= cnt_i);
   end

   assign eff_d  = mask_i & win;
   assign sidx_d = (eff_d == '0) ? cnt_i : CW'(top_set_bit(64'(eff_d)));

   logic [CW-1:0]     k_q;
   logic [CW-1:0]     lim_q;
   logic [CW-1:0]     sidx_q;
   logic [MASK_W-1:0] eff_q;
   logic              act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q    <= '0;
         lim_q  <= '0;
         sidx_q <= '0;
         eff_q  <= '0;
         act_q  <= 1'b0;
      end else if (go_i) begin
         k_q    <= '0;
         lim_q  <= cnt_i;
         sidx_q <= sidx_d;
         eff_q  <= eff_d;
         act_q  <= 1'b1;
      end else if (act_q) begin
         if (k_q == lim_q) act_q <= 1'b0;
         else              k_q   <= k_q + 1'b1;
      end
   end

   assign active_o = act_q;
   assign rd_act_o = act_q & eff_q[k_q];
   assign sample_o = act_q & (k_q == sidx_q);
   assign last_o   = act_q & (k_q == lim_q);

   // R6: strobe only during the window
   assert_rd_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act_o |-> active_o);

   // R7: capture point never after the window end
   assert_sample_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !sample_o |=> !sample_o);

endmodule

// File: rtl/prom_byte_reader.sv
module prom_byte_reader
   import prom_rd_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int MASK_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [8*ADDR_BYTES-1:0]       addr_i,
   input  logic [MASK_W-1:0]             strobe_mask_i,
   input  logic [$clog2(MASK_W)-1:0]     access_cnt_i,
   output logic                          busy_o,
   output logic [7:0]                    data_o,
   output logic                          data_valid_o,
   output logic [7:0]                    bus_out_o,
   output logic                          bus_oe_o,
   input  logic [7:0]                    bus_in_i,
   output logic                          rom_clk_o,
   output logic                          ale_n_o,
   output logic                          cs_n_o,
   output logic                          rd_n_o
);
   localparam int CW = $clog2(MASK_W);

   rd_state_e         state_q;
   logic [MASK_W-1:0] mask_q;
   logic [CW-1:0]     cnt_q;
   logic [7:0]        data_q;
   logic              valid_q;

   logic accept, ser_last, tmr_go;
   logic tmr_active, tmr_rd, tmr_sample, tmr_last;
   logic [7:0] ser_byte;
   logic ser_clk;

   assign accept = (state_q == ST_IDLE) & start_i;
   assign tmr_go = (state_q == ST_ADDR) & ser_last;

   prom_addr_serializer #(.BYTES(ADDR_BYTES)) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept),
      .addr_i      (addr_i),
      .byte_o      (ser_byte),
      .rom_clk_o   (ser_clk),
      .last_rise_o (ser_last)
   );

   prom_strobe_timer #(.MASK_W(MASK_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (tmr_go),
      .mask_i   (mask_q),
      .cnt_i    (cnt_q),
      .active_o (tmr_active),
      .rd_act_o (tmr_rd),
      .sample_o (tmr_sample),
      .last_o   (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_ADDR;
               mask_q  <= strobe_mask_i;
               cnt_q   <= access_cnt_i;
            end
            ST_ADDR:   if (ser_last) state_q <= ST_ACCESS;
            ST_ACCESS: if (tmr_last) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (accept) valid_q <= 1'b0;
         else if (state_q == ST_ACCESS && tmr_last) valid_q <= 1'b1;
         if (state_q == ST_ACCESS && tmr_sample) data_q <= bus_in_i;
      end
   end

   assign busy_o       = (state_q != ST_IDLE);
   assign data_o       = data_q;
   assign data_valid_o = valid_q;
   assign bus_out_o    = ser_byte;
   assign bus_oe_o     = (state_q == ST_ADDR);
   assign rom_clk_o    = ser_clk;
   assign ale_n_o      = ~(state_q == ST_ADDR);
   assign cs_n_o       = ~tmr_active;
   assign rd_n_o       = ~((state_q == ST_ACCESS) & tmr_rd);

   // R3: latch enable released only after a ROM clock high phase
   assert_ale_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_n_o) |-> $past(rom_clk_o));

   // R5: bus never driven while the ROM is selected
   assert_bus_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> !bus_oe_o);

   // R6: strobe nested inside chip select
   assert_rd_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cs_n_o);

   // R9: a request during a read leaves the settings alone
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(mask_q) && $stable(cnt_q));

   // R10: result held while idle and not restarted
   assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(data_o) && $stable(data_valid_o));

endmodule

// File: tb/prom_byte_reader_tb.sv
module prom_byte_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] addr = '0;
   logic [15:0] mask = '0;
   logic [3:0]  cnt = '0;
   logic        busy, dvalid, bus_oe, rom_clk, ale_n, cs_n, rd_n;
   logic [7:0]  data, bus_out, bus_in;

   logic [7:0]  ext1 = '0, ext2 = '0, ext3 = '0;
   int          rises = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   prom_byte_reader u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
      .strobe_mask_i(mask), .access_cnt_i(cnt), .busy_o(busy),
      .data_o(data), .data_valid_o(dvalid), .bus_out_o(bus_out),
      .bus_oe_o(bus_oe), .bus_in_i(bus_in), .rom_clk_o(rom_clk),
      .ale_n_o(ale_n), .cs_n_o(cs_n), .rd_n_o(rd_n)
   );

   function automatic logic [7:0] rom_byte(input logic [23:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hA5;
   endfunction

   // External cascaded address registers and ROM array model.
   always @(posedge rom_clk) begin
      ext3 <= ext2;
      ext2 <= ext1;
      ext1 <= bus_out;
      rises <= rises + 1;
   end
   assign bus_in = (!cs_n && !rd_n) ? rom_byte({ext3, ext2, ext1}) : 8'hFF;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [23:0] a, input logic [15:0] m, input logic [3:0] c, input bit inject);
      logic [15:0] eff;
      logic [7:0]  exp_data;
      int r0, last_n;
      int bad_ale, bad_cs, bad_rd, bad_busy, bad_clk, bad_bus, bad_oe;
      eff = '0;
      for (int i = 0; i < 16; i++) if (i <= int'(c)) eff[i] = m[i];
      exp_data = (eff == '0) ? 8'hFF : rom_byte(a);
      bad_ale = 0; bad_cs = 0; bad_rd = 0; bad_busy = 0; bad_clk = 0; bad_bus = 0; bad_oe = 0;
      last_n = 8 + int'(c);
      r0 = rises;
      @(negedge clk);
      start = 1'b1; addr = a; mask = m; cnt = c;
      @(negedge clk);
      start = 1'b0;
      for (int n = 1; n <= last_n; n++) begin
         bit ale_e, cs_e, rd_e, busy_e, clk_e, oe_e;
         ale_e  = !(n >= 1 && n <= 6);
         oe_e   = (n >= 1 && n <= 6);
         clk_e  = (n == 2 || n == 4 || n == 6);
         cs_e   = !(n >= 7 && n <= 7 + int'(c));
         rd_e   = !(!cs_e && eff[n-7]);
         busy_e = (n <= 7 + int'(c));
         if (n == 1) chk(dvalid == 1'b0, "R10 valid cleared on accept", dvalid, 0);
         if (ale_n != ale_e) bad_ale++;
         if (cs_n != cs_e) bad_cs++;
         if (rd_n != rd_e) bad_rd++;
         if (busy != busy_e) bad_busy++;
         if (rom_clk != clk_e) bad_clk++;
         if (bus_oe != oe_e) bad_oe++;
         if (oe_e && bus_out != a[23 - 8*((n-1)/2) -: 8]) bad_bus++;
         if (inject && n == 3) begin
            start = 1'b1; addr = ~a; mask = 16'hFFFF; cnt = 4'hF;
         end
         if (inject && n == 4) start = 1'b0;
         @(negedge clk);
      end
      chk(bad_bus == 0 && bad_oe == 0, "R2 beat order and driver enable", bad_bus, 0);
      chk({ext3, ext2, ext1} == a, "R2 reconstructed address", {ext3, ext2, ext1}, a);
      chk(bad_ale == 0, "R3 latch enable timing", bad_ale, 0);
      chk(bad_clk == 0 && rises - r0 == 3, "R4 ROM clock phases and edge count", rises - r0, 3);
      chk(bad_cs == 0, "R5 chip select window", bad_cs, 0);
      chk(bad_rd == 0, "R6 strobe pattern", bad_rd, 0);
      chk(data == exp_data, "R7 captured byte", data, exp_data);
      chk(bad_busy == 0 && dvalid == 1'b1, "R8 busy and completion", bad_busy, 0);
      if (inject) chk(data == exp_data && {ext3, ext2, ext1} == a, "R9 start while busy ignored", data, exp_data);
   endtask

   initial begin
      logic [7:0] held;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({ale_n, cs_n, rd_n} == 3'b111, "R1 strobes inactive", {ale_n, cs_n, rd_n}, 3'b111);
      chk({bus_oe, rom_clk, busy, dvalid} == 4'b0, "R1 driver, clock, busy, valid", {bus_oe, rom_clk, busy, dvalid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ale_n, cs_n, rd_n, bus_oe, rom_clk} == 5'b11100, "R1 after release", {ale_n, cs_n, rd_n, bus_oe, rom_clk}, 5'b11100);

      do_read(24'h123456, 16'h0006, 4'd3, 1'b0);
      do_read(24'hFFFFFF, 16'h0001, 4'd0, 1'b0);
      do_read(24'h000000, 16'h0000, 4'd4, 1'b0);   // R7 empty mask
      do_read(24'hA5C30F, 16'hFF00, 4'd3, 1'b0);   // R7 mask outside window
      do_read(24'h80FF01, 16'h8001, 4'd15, 1'b0);  // R5 longest window
      do_read(24'h5A5A5A, 16'h00F0, 4'd9, 1'b1);   // R9 request during read

      // R10 hold while idle
      held = data;
      repeat (5) @(negedge clk);
      chk(data == held && dvalid == 1'b1, "R10 result held while idle", data, held);

      for (int t = 0; t < 20; t++) begin
         do_read(24'($urandom), 16'($urandom), 4'($urandom), t % 5 == 0);
         repeat ($urandom % 3) @(negedge clk);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule